// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of a single-data-rate SDRAM and owns the command pins for two jobs. The first is the bring-up sequence after reset. It drives NOP with clock enable and the data mask high for the stabilisation wait. It then precharges all banks, issues a programmable number of auto-refresh commands and writes the mode register. After the mode-register write it observes the two-cycle lockout and then raises `init_done`.

Once initialized, the block keeps its own refresh schedule. A refresh becomes owed once every refresh interval. The user side holds `user_busy` while it owns the bus, and owed refreshes accumulate during that time. When the user lets go, the sequencer claims the bus through `refresh_busy`. It closes any open bank with a precharge-all and issues every owed refresh back to back at the refresh cycle spacing. `refresh_urgent` tells the user that the postponement limit of eight has been reached.

Every wait is a parameter in picoseconds. It is turned into a cycle count by dividing by the clock period and rounding up.

Top module: `sdram_initref_seq`

## Requirements
- R1: After reset release the command is NOP ({cs_n,ras_n,cas_n,we_n}=0111), with cke=1 and dqm=1. This holds until the precharge-all, which appears on clock edge N_PWR = ceil(T_PWR_PS/CLK_PERIOD_PS) after reset release. cke stays 1 at all times.
- R2: Precharge-all is encoded 0010 with addr bit 10 set, every other addr bit 0 and ba=0. The next command comes exactly N_RP = ceil(T_RP_PS/CLK_PERIOD_PS) edges after it.
- R3: During bring-up, INIT_REFS auto-refresh commands (encoding 0001) are issued. They are spaced exactly N_RFC = ceil(T_RFC_PS/CLK_PERIOD_PS) edges apart, and the first one comes N_RP edges after the precharge-all.
- R4: The mode-register write (encoding 0000) comes N_RFC edges after the last bring-up refresh, with ba=0. Its address carries the burst-length code in bits 2..0, the burst type in bit 3, the CAS latency in bits 6..4 and the single-write mode in bit 9, with all other bits 0. The defaults give 12'h033.
- R5: init_done rises exactly 2 edges after the mode-register write and then stays high. From then on dqm is 0.
- R6: Every wait count is the time parameter divided by the clock period, rounded up to the next integer. With an 8 ns clock, T_RFC_PS=70000 therefore gives 9 cycles.
- R7: From the edge on which init_done rises, one refresh becomes owed every N_REFI = ceil(T_REFI_PS/CLK_PERIOD_PS) edges, and each refresh issued pays one back. refresh_urgent is 1 exactly when 8 (MAX_OWED) or more are owed.
- R8: While user_busy is high, the idle sequencer starts no refresh and drives only NOP, however many refreshes are owed.
- R9: With refreshes owed, user_busy sampled low in idle raises refresh_busy on the next edge, with NOP driven. On the edge after that, a refresh is issued if banks_open is 0. If banks_open is 1, a precharge-all is issued instead and the first refresh follows N_RP edges later.
- R10: All owed refreshes, up to 8, are issued back to back at N_RFC spacing. refresh_busy falls N_RFC edges after the last one, and the owed count is then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| user_busy | input | 1 | User side holds the command bus |
| banks_open | input | 1 | At least one bank has an open row |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable, held high |
| dqm | output | 1 | Data mask, high until init_done |
| addr | output | ADDR_W | Address lines (precharge-all flag, mode word) |
| ba | output | BA_W | Bank address, always 0 |
| init_done | output | 1 | Bring-up complete |
| refresh_busy | output | 1 | Sequencer owns the bus for refresh |
| refresh_urgent | output | 1 | Postponement limit reached |

## Verification
Bring-up is observed once, with `user_busy` held high throughout. This confirms that the sequence ignores the user side and lets every command's edge number be compared with the rounded-up counts. The main sweep postpones 1 through 8 refreshes, and alternates `banks_open` between sweeps. Each sweep distinguishes a correct owed count, a missing or extra refresh in the burst, wrong spacing, and a missing precharge before refresh. The sweep at 8 separates the urgent flag's threshold from its neighbours. A per-cycle model of the owed count tracks the urgent flag across the whole run.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // Command encoding on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_PRE_WAIT,
    ST_INIT_RFC,
    ST_MRD,
    ST_IDLE,
    ST_GRAB,
    ST_R_PRE_WAIT,
    ST_R_RFC
  } seq_state_e;

  // Minimum time over clock period, rounded up
  function automatic int ceil_cycles(input int t_ps, input int period_ps);
    return (t_ps + period_ps - 1) / period_ps;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sdram_seq_timer.sv
module sdram_seq_timer #(
  parameter int TW      = 16,
  parameter int RST_VAL = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;

  always_comb begin
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= TW'(RST_VAL);
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_refresh_credit.sv
module sdram_refresh_credit #(
  parameter int N_REFI   = 1950,
  parameter int MAX_OWED = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            en,
  input  logic                            consume,
  output logic [$clog2(MAX_OWED+1)-1:0]   owed,
  output logic                            pending,
  output logic                            urgent
);

  localparam int IW = $clog2(N_REFI + 1);
  localparam int OW = $clog2(MAX_OWED + 1);

  logic [IW-1:0] icnt_q, icnt_d;
  logic [OW-1:0] owed_q, owed_d;
  logic          tick;

  assign tick = en && (icnt_q == IW'(N_REFI - 1));

  always_comb begin
    if (!en || tick) begin
      icnt_d = '0;
    end else begin
      icnt_d = icnt_q + 1'b1;
    end
  end

  always_comb begin
    owed_d = owed_q;
    case ({tick, consume})
      2'b10:   if (owed_q != OW'(MAX_OWED)) owed_d = owed_q + 1'b1;
      2'b01:   if (owed_q != '0) owed_d = owed_q - 1'b1;
      default: owed_d = owed_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt_q <= '0;
      owed_q <= '0;
    end else begin
      icnt_q <= icnt_d;
      owed_q <= owed_d;
    end
  end

  assign owed    = owed_q;
  assign pending = (owed_q != '0);
  assign urgent  = (owed_q >= OW'(MAX_OWED));

  // R7
  owed_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= OW'(MAX_OWED));

  // R7
  owed_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_q == $past(owed_q)) || (owed_q == $past(owed_q) + 1'b1) ||
    (owed_q == $past(owed_q) - 1'b1));

  // R10
  consume_needs_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> (owed_q != '0));

endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
  import sdram_seq_pkg::*;
#(
  parameter int N_RP      = 3,
  parameter int N_RFC     = 9,
  parameter int N_MRD     = 2,
  parameter int INIT_REFS = 2,
  parameter int ADDR_W    = 12,
  parameter int TW        = 16,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_zero,
  input  logic              pending,
  input  logic              user_busy,
  input  logic              banks_open,
  output logic              tmr_load,
  output logic [TW-1:0]     tmr_val,
  output logic              consume,
  output sdram_cmd_e        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              refresh_busy
);

  localparam int RW = $clog2(INIT_REFS + 1);
  localparam logic [ADDR_W-1:0] PRE_ALL_WORD = ADDR_W'(1) << 10;

  seq_state_e        state_q, state_d;
  sdram_cmd_e        cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q, done_d;
  logic [RW-1:0]     refs_q, refs_d;

  always_comb begin
    state_d  = state_q;
    cmd_d    = CMD_NOP;
    addr_d   = '0;
    done_d   = done_q;
    refs_d   = refs_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    consume  = 1'b0;
    case (state_q)
      ST_PWR: if (tmr_zero) begin
        cmd_d    = CMD_PRE;
        addr_d   = PRE_ALL_WORD;
        tmr_load = 1'b1;
        tmr_val  = TW'(N_RP - 1);
        state_d  = ST_PRE_WAIT;
      end
      ST_PRE_WAIT: if (tmr_zero) begin
        cmd_d    = CMD_REF;
        tmr_load = 1'b1;
        tmr_val  = TW'(N_RFC - 1);
        refs_d   = refs_q + 1'b1;
        state_d  = ST_INIT_RFC;
      end
      ST_INIT_RFC: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (refs_q < RW'(INIT_REFS)) begin
          cmd_d   = CMD_REF;
          tmr_val = TW'(N_RFC - 1);
          refs_d  = refs_q + 1'b1;
        end else begin
          cmd_d   = CMD_MRS;
          addr_d  = MODE_WORD;
          tmr_val = TW'(N_MRD - 1);
          state_d = ST_MRD;
        end
      end
      ST_MRD: if (tmr_zero) begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      ST_IDLE: if (pending && !user_busy) begin
        state_d = ST_GRAB;
      end
      ST_GRAB: begin
        tmr_load = 1'b1;
        if (banks_open) begin
          cmd_d   = CMD_PRE;
          addr_d  = PRE_ALL_WORD;
          tmr_val = TW'(N_RP - 1);
          state_d = ST_R_PRE_WAIT;
        end else begin
          cmd_d   = CMD_REF;
          tmr_val = TW'(N_RFC - 1);
          consume = 1'b1;
          state_d = ST_R_RFC;
        end
      end
      ST_R_PRE_WAIT: if (tmr_zero) begin
        cmd_d    = CMD_REF;
        tmr_load = 1'b1;
        tmr_val  = TW'(N_RFC - 1);
        consume  = 1'b1;
        state_d  = ST_R_RFC;
      end
      ST_R_RFC: if (tmr_zero) begin
        if (pending) begin
          cmd_d    = CMD_REF;
          tmr_load = 1'b1;
          tmr_val  = TW'(N_RFC - 1);
          consume  = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PWR;
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
      done_q  <= 1'b0;
      refs_q  <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      done_q  <= done_d;
      refs_q  <= refs_d;
    end
  end

  assign cmd          = cmd_q;
  assign addr         = addr_q;
  assign init_done    = done_q;
  assign refresh_busy = (state_q == ST_GRAB) || (state_q == ST_R_PRE_WAIT) ||
                        (state_q == ST_R_RFC);

  // R5
  init_done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);

  // R5
  init_done_after_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_MRS) |=> (cmd_q == CMD_NOP) && !done_q);

  // R8
  no_grab_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && user_busy) |=> (cmd_q == CMD_NOP) && !refresh_busy);

  // R2
  pre_all_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PRE) |-> (addr_q == PRE_ALL_WORD));

  generate
    if (N_RFC > 1) begin : g_rfc_gap
      // R10
      nop_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_REF) |=> (cmd_q == CMD_NOP));
    end
  endgenerate

endmodule

// File: rtl/sdram_initref_seq.sv
module sdram_initref_seq
  import sdram_seq_pkg::*;
#(
  parameter int CLK_PERIOD_PS    = 8000,
  parameter int T_PWR_PS         = 200_000_000,
  parameter int T_RP_PS          = 20_000,
  parameter int T_RFC_PS         = 70_000,
  parameter int T_REFI_PS        = 15_600_000,
  parameter int MRD_CYCLES       = 2,
  parameter int INIT_REFS        = 2,
  parameter int MAX_OWED         = 8,
  parameter int ADDR_W           = 12,
  parameter int BA_W             = 2,
  parameter int BL_CODE          = 3,
  parameter int BURST_INTERLEAVE = 0,
  parameter int CAS_LAT          = 3,
  parameter int WRITE_SINGLE     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              user_busy,
  input  logic              banks_open,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              cke,
  output logic              dqm,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              init_done,
  output logic              refresh_busy,
  output logic              refresh_urgent
);

  localparam int N_PWR  = ceil_cycles(T_PWR_PS, CLK_PERIOD_PS);
  localparam int N_RP   = ceil_cycles(T_RP_PS, CLK_PERIOD_PS);
  localparam int N_RFC  = ceil_cycles(T_RFC_PS, CLK_PERIOD_PS);
  localparam int N_REFI = ceil_cycles(T_REFI_PS, CLK_PERIOD_PS);
  localparam int TW     = $clog2(max3(N_PWR, N_RP, N_RFC) + 1);
  localparam int OW     = $clog2(MAX_OWED + 1);
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(
    ((WRITE_SINGLE & 1) << 9) | ((CAS_LAT & 7) << 4) |
    ((BURST_INTERLEAVE & 1) << 3) | (BL_CODE & 7));

  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;
  logic          consume;
  logic          pending;
  logic [OW-1:0] owed;
  sdram_cmd_e    cmd;

  sdram_seq_timer #(
    .TW      (TW),
    .RST_VAL (N_PWR - 1)
  ) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sdram_refresh_credit #(
    .N_REFI   (N_REFI),
    .MAX_OWED (MAX_OWED)
  ) i_credit (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (init_done),
    .consume (consume),
    .owed    (owed),
    .pending (pending),
    .urgent  (refresh_urgent)
  );

  sdram_seq_fsm #(
    .N_RP      (N_RP),
    .N_RFC     (N_RFC),
    .N_MRD     (MRD_CYCLES),
    .INIT_REFS (INIT_REFS),
    .ADDR_W    (ADDR_W),
    .TW        (TW),
    .MODE_WORD (MODE_WORD)
  ) i_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .tmr_zero     (tmr_zero),
    .pending      (pending),
    .user_busy    (user_busy),
    .banks_open   (banks_open),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .consume      (consume),
    .cmd          (cmd),
    .addr         (addr),
    .init_done    (init_done),
    .refresh_busy (refresh_busy)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke = 1'b1;
  assign dqm = ~init_done;
  assign ba  = '0;

  // R7
  urgent_only_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_urgent |-> (owed != '0) && init_done);

endmodule

// File: tb/test_sdram_initref_seq.sv
module test_sdram_initref_seq;

  localparam int P      = 8000;
  localparam int TPWR   = 4_001_000;
  localparam int TRP    = 20_000;
  localparam int TRFC   = 70_000;
  localparam int TREFI  = 1_600_000;
  localparam int EN_PWR  = (TPWR + P - 1) / P;
  localparam int EN_RP   = (TRP + P - 1) / P;
  localparam int EN_RFC  = (TRFC + P - 1) / P;
  localparam int EN_REFI = (TREFI + P - 1) / P;
  localparam logic [11:0] EXP_MODE = 12'h033;
  localparam logic [11:0] EXP_PRE  = 12'h400;
  localparam logic [3:0] C_NOP = 4'b0111, C_REF = 4'b0001,
                         C_PRE = 4'b0010, C_MRS = 4'b0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic user_busy = 1'b1;
  logic banks_open = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, cke, dqm;
  logic [11:0] addr;
  logic [1:0]  ba;
  logic init_done, refresh_busy, refresh_urgent;
  logic [3:0] cmdv;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int d_cyc = -1;
  int refs_post = 0;
  int model_owed = 0;
  int urg_err = 0;
  int pw_err = 0;
  int dqm_err = 0;
  bit finished = 1'b0;

  assign cmdv = {cs_n, ras_n, cas_n, we_n};

  always #4 clk = ~clk;

  sdram_initref_seq #(
    .CLK_PERIOD_PS (P),
    .T_PWR_PS      (TPWR),
    .T_RP_PS       (TRP),
    .T_RFC_PS      (TRFC),
    .T_REFI_PS     (TREFI)
  ) i_sdram_initref_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .user_busy      (user_busy),
    .banks_open     (banks_open),
    .cs_n           (cs_n),
    .ras_n          (ras_n),
    .cas_n          (cas_n),
    .we_n           (we_n),
    .cke            (cke),
    .dqm            (dqm),
    .addr           (addr),
    .ba             (ba),
    .init_done      (init_done),
    .refresh_busy   (refresh_busy),
    .refresh_urgent (refresh_urgent)
  );

  // Cycle monitor, sampling 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      cyc = 0;
    end else begin
      cyc = cyc + 1;
      if (cke !== 1'b1) pw_err++;
      if (d_cyc < 0 && init_done === 1'b1) d_cyc = cyc;
      if (d_cyc >= 0) begin
        if (cmdv == C_REF) refs_post++;
        model_owed = (cyc - d_cyc) / EN_REFI - refs_post;
        if (refresh_urgent !== (model_owed >= 8)) urg_err++;
        if (dqm !== 1'b0) dqm_err++;
      end else if (dqm !== 1'b1) begin
        pw_err++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_cmd(output logic [3:0] c, output int at);
    int n;
    n = 0;
    do begin
      step();
      n++;
    end while (cmdv == C_NOP && n < 3000);
    c = cmdv;
    at = cyc;
  endtask

  initial begin
    logic [3:0] c;
    int at, t_pre, t_ref, t_mrs, e, busy_cmds, last;
    repeat (3) step();
    // R1 reset state
    chk(cmdv == C_NOP && cke && dqm && !init_done && !refresh_busy,
        "R1 reset state", int'({cmdv, cke, dqm, init_done}), int'({C_NOP, 3'b110}));
    rst_n = 1'b1;

    wait_cmd(c, t_pre);
    chk(c == C_PRE, "R1 first command is precharge", int'(c), int'(C_PRE));
    chk(t_pre == EN_PWR, "R1 R6 power-up wait edges", t_pre, EN_PWR);
    chk(addr == EXP_PRE && ba == 2'b00, "R2 precharge-all address", int'(addr), int'(EXP_PRE));

    wait_cmd(c, t_ref);
    chk(c == C_REF, "R3 first init refresh", int'(c), int'(C_REF));
    chk(t_ref - t_pre == EN_RP, "R2 R6 precharge wait", t_ref - t_pre, EN_RP);
    wait_cmd(c, at);
    chk(c == C_REF, "R3 second init refresh", int'(c), int'(C_REF));
    chk(at - t_ref == EN_RFC, "R3 R6 refresh spacing", at - t_ref, EN_RFC);
    t_ref = at;

    wait_cmd(c, t_mrs);
    chk(c == C_MRS, "R4 mode register write", int'(c), int'(C_MRS));
    chk(t_mrs - t_ref == EN_RFC, "R4 mode write after refresh", t_mrs - t_ref, EN_RFC);
    chk(addr == EXP_MODE && ba == 2'b00, "R4 mode word", int'(addr), int'(EXP_MODE));

    while (!init_done && cyc < t_mrs + 10) step();
    chk(d_cyc == t_mrs + 2, "R5 init_done lockout", d_cyc, t_mrs + 2);
    chk(dqm == 1'b0, "R5 dqm low after init", int'(dqm), 0);

    // Sweep: postpone k refreshes, then release the bus
    for (int k = 1; k <= 8; k++) begin
      banks_open = k[0];
      busy_cmds = 0;
      while (model_owed != k && cyc < 150000) begin
        step();
        if (cmdv != C_NOP || refresh_busy) busy_cmds++;
      end
      chk(busy_cmds == 0, "R8 no command while user busy", busy_cmds, 0);
      chk(refresh_urgent == (k >= 8), "R7 urgent flag", int'(refresh_urgent), int'(k >= 8));
      user_busy = 1'b0;
      e = cyc;
      step();
      chk(refresh_busy && cmdv == C_NOP, "R9 grab cycle", int'({refresh_busy, cmdv}), int'({1'b1, C_NOP}));
      step();
      if (banks_open) begin
        chk(cmdv == C_PRE && cyc == e + 2 && addr == EXP_PRE, "R9 precharge before refresh",
            int'(cmdv), int'(C_PRE));
        wait_cmd(c, at);
        chk(c == C_REF && at == e + 2 + EN_RP, "R9 refresh after precharge", at, e + 2 + EN_RP);
      end else begin
        chk(cmdv == C_REF && cyc == e + 2, "R9 direct refresh", int'(cmdv), int'(C_REF));
        at = cyc;
      end
      last = at;
      for (int j = 1; j < k; j++) begin
        wait_cmd(c, at);
        chk(c == C_REF && at - last == EN_RFC, "R10 burst spacing", at - last, EN_RFC);
        last = at;
      end
      while (cyc < last + EN_RFC - 1) begin
        step();
        if (cmdv != C_NOP) busy_cmds++;
      end
      chk(refresh_busy && busy_cmds == 0, "R10 busy held through last refresh",
          int'(refresh_busy), 1);
      step();
      chk(!refresh_busy && model_owed == 0, "R10 busy falls, nothing owed",
          int'(refresh_busy) * 100 + model_owed, 0);
      user_busy = 1'b1;
    end

    chk(urg_err == 0, "R7 urgent tracks owed count", urg_err, 0);
    chk(pw_err == 0, "R1 cke and dqm high during bring-up", pw_err, 0);
    chk(dqm_err == 0, "R5 dqm low after init", dqm_err, 0);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    summary();
  end

endmodule